// File: doc/BRIEF.md
# Sequential Page Program Buffer Loader

This block gathers the data phase of a page-program command into an on-chip page buffer. Once the command decoder has seen the page-program opcode (41H), it pulses `cmd_start`. Every bus write cycle that completes after that pulse carries one address and one data item for the page. The loader recognises the end of each write cycle from the write-enable and chip-enable inputs. It checks that the page offsets arrive in strict ascending order from zero and that all writes stay in one page. It then stores each item in the buffer.

In word mode the page is 128 words of 16 bits. In byte mode it is 256 bytes. A byte-mode write carries one more low address bit, the byte-select bit, which on the package shares a pin with the top data bit. Each byte is placed in the low or the high half of a 16-bit buffer word according to that bit. When the last entry is stored, the loader offers the page to the program engine. It raises `page_valid`, presents the page base address, and lets the engine read any buffer word through a read index. It holds all of this until `page_ready` is seen. An out-of-order write or a write to another page ends the load early: `seq_error` is set and no page is offered.

Top module: `plb_page_loader`

## Requirements
- R1: After reset `page_valid` and `seq_error` are 0 and the loader is idle, so write cycles that complete before any `cmd_start` store nothing and never raise `page_valid` or `seq_error`.
- R2: A write cycle is the span in which `bus_we_n` and `bus_ce_n` are both 0. It completes in the first cycle in which either of them is 1 again, whichever rises first. It delivers the address, byte-select bit and data held in the last cycle of that span, once per cycle.
- R3: In word mode (`byte_mode` = 0 at start) the page offset is `bus_addr[6:0]`. The page ends at offset 127, and the full 16-bit `bus_data` of an entry at offset k is stored in buffer word k.
- R4: In byte mode (`byte_mode` = 1 at start) the page offset is {`bus_addr[6:0]`, `bus_lsb`} with `bus_lsb` as the least significant bit, and the page ends at offset 255. `bus_data[7:0]` goes to bits 7:0 of buffer word `bus_addr[6:0]` when `bus_lsb` = 0, and to bits 15:8 when it is 1. `bus_data[15:8]` is ignored, as is any change of `byte_mode` after `cmd_start`.
- R5: Offsets must arrive exactly as 0, 1, 2, and so on. A write with any other offset sets `seq_error` to 1 and returns the loader to idle without storing it. `page_valid` is not raised for that load.
- R6: The page base `bus_addr[18:7]` is taken from the write at offset 0. A later write whose upper address bits differ is rejected exactly like an out-of-order write (R5).
- R7: One cycle after the last entry is stored, `page_valid` is 1 and `page_base` shows the latched base. Both, and every buffer word on `rd_index`/`rd_data`, stay unchanged while `page_ready` is 0. In the cycle after `page_valid` and `page_ready` are both 1, `page_valid` is 0 and the loader is idle.
- R8: Write cycles that complete while the loader is idle or while `page_valid` is 1 leave the buffer unchanged.
- R9: `cmd_start` while idle or loading restarts the load at offset 0, clears `seq_error` and samples `byte_mode`. A write completing in the same cycle is dropped. `cmd_start` while `page_valid` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | One-cycle pulse: page-program opcode accepted |
| bus_we_n | input | 1 | Write enable, active low, sampled each cycle |
| bus_ce_n | input | 1 | Chip enable, active low, sampled each cycle |
| bus_addr | input | 19 | Word address of the write |
| bus_lsb | input | 1 | Byte-select low address bit (byte mode only) |
| bus_data | input | 16 | Write data |
| byte_mode | input | 1 | 1 = byte-wide page, 0 = word-wide page |
| page_ready | input | 1 | Program engine accepts the offered page |
| rd_index | input | 7 | Buffer word index to read |
| page_valid | output | 1 | Full page available in the buffer |
| page_base | output | 12 | Upper address bits of the page |
| rd_data | output | 16 | Buffer word at `rd_index` |
| seq_error | output | 1 | Last load aborted by an order or page mismatch |

## Verification
Two functions can fall in the same cycle: a new `cmd_start` and the end of a bus write. The bench places the start pulse on the very cycle in which write-enable rises on the offset-1 write of a running load, and then writes a full page from offset 0. That page is valid with the new data only if the coinciding write was dropped; if it had been stored, the restarted load would flag a sequence error. The second overlap is a start pulse and a bus write while a finished page waits for the program engine. Here `page_valid`, the base and buffer word 0 must all come through unchanged.

// File: rtl/plb_pkg.sv
package plb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_FULL = 2'd2
    } plb_state_e;

endpackage

// File: rtl/plb_cycle_detect.sv
module plb_cycle_detect #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic              ce_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              lsb,
    input  logic [DATA_W-1:0] data,
    output logic              strobe,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              cap_lsb,
    output logic [DATA_W-1:0] cap_data
);

    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] addr;
        logic              lsb;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t r_d, r_q;
    logic active_now;

    always_comb begin
        active_now = !we_n && !ce_n;
        r_d        = r_q;
        r_d.active = active_now;
        if (active_now) begin
            r_d.addr = addr;
            r_d.lsb  = lsb;
            r_d.data = data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // the cycle closes on the first of the two enables to go high
    assign strobe   = r_q.active && !active_now;
    assign cap_addr = r_q.addr;
    assign cap_lsb  = r_q.lsb;
    assign cap_data = r_q.data;

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

endmodule

// File: rtl/plb_page_store.sv
module plb_page_store #(
    parameter int PAGE_AW = 7,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [PAGE_AW-1:0] wr_idx,
    input  logic [1:0]         wr_be,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [PAGE_AW-1:0] rd_idx,
    output logic [DATA_W-1:0]  rd_data
);

    localparam int WORDS  = 1 << PAGE_AW;
    localparam int HALF_W = DATA_W / 2;

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [HALF_W-1:0] mem_q [WORDS];

        always_ff @(posedge clk) begin
            if (wr_en && wr_be[h]) begin
                mem_q[wr_idx] <= wr_data[h*HALF_W +: HALF_W];
            end
        end

        assign rd_data[h*HALF_W +: HALF_W] = mem_q[rd_idx];
    end

endmodule

// File: rtl/plb_page_loader.sv
module plb_page_loader #(
    parameter int ADDR_W  = 19,
    parameter int PAGE_AW = 7,
    parameter int DATA_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_start,
    input  logic                       bus_we_n,
    input  logic                       bus_ce_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_lsb,
    input  logic [DATA_W-1:0]          bus_data,
    input  logic                       byte_mode,
    input  logic                       page_ready,
    input  logic [PAGE_AW-1:0]         rd_index,
    output logic                       page_valid,
    output logic [ADDR_W-PAGE_AW-1:0]  page_base,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       seq_error
);

    import plb_pkg::*;

    localparam int OFF_W  = PAGE_AW + 1;
    localparam int BASE_W = ADDR_W - PAGE_AW;
    localparam int WORDS  = 1 << PAGE_AW;
    localparam int HALF_W = DATA_W / 2;
    localparam logic [OFF_W-1:0] LAST_WORD = OFF_W'(WORDS - 1);
    localparam logic [OFF_W-1:0] LAST_BYTE = OFF_W'(2 * WORDS - 1);

    typedef struct packed {
        plb_state_e        state;
        logic [OFF_W-1:0]  expect_off;
        logic [BASE_W-1:0] base;
        logic              bmode;
        logic              err;
    } ctl_t;

    ctl_t r_d, r_q;

    logic              strobe;
    logic [ADDR_W-1:0] cap_addr;
    logic              cap_lsb;
    logic [DATA_W-1:0] cap_data;

    logic [OFF_W-1:0]  offset;
    logic [OFF_W-1:0]  last_off;
    logic [BASE_W-1:0] base_in;
    logic              seq_ok;
    logic              store_we;
    logic [1:0]        store_be;
    logic [DATA_W-1:0] store_data;

    plb_cycle_detect #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_cycle (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_n     (bus_we_n),
        .ce_n     (bus_ce_n),
        .addr     (bus_addr),
        .lsb      (bus_lsb),
        .data     (bus_data),
        .strobe   (strobe),
        .cap_addr (cap_addr),
        .cap_lsb  (cap_lsb),
        .cap_data (cap_data)
    );

    plb_page_store #(
        .PAGE_AW (PAGE_AW),
        .DATA_W  (DATA_W)
    ) i_store (
        .clk     (clk),
        .wr_en   (store_we),
        .wr_idx  (cap_addr[PAGE_AW-1:0]),
        .wr_be   (store_be),
        .wr_data (store_data),
        .rd_idx  (rd_index),
        .rd_data (rd_data)
    );

    always_comb begin
        // byte offsets put the byte-select bit below the word index
        offset   = r_q.bmode ? {cap_addr[PAGE_AW-1:0], cap_lsb}
                             : {1'b0, cap_addr[PAGE_AW-1:0]};
        last_off = r_q.bmode ? LAST_BYTE : LAST_WORD;
        base_in  = cap_addr[ADDR_W-1:PAGE_AW];
        seq_ok   = (offset == r_q.expect_off) &&
                   ((r_q.expect_off == '0) || (base_in == r_q.base));

        store_be   = r_q.bmode ? (cap_lsb ? 2'b10 : 2'b01) : 2'b11;
        store_data = r_q.bmode ? {2{cap_data[HALF_W-1:0]}} : cap_data;
        store_we   = 1'b0;

        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE, ST_LOAD: begin
                if (cmd_start) begin
                    r_d.state      = ST_LOAD;
                    r_d.expect_off = '0;
                    r_d.err        = 1'b0;
                    r_d.bmode      = byte_mode;
                end else if (strobe && (r_q.state == ST_LOAD)) begin
                    if (seq_ok) begin
                        store_we = 1'b1;
                        if (r_q.expect_off == '0) begin
                            r_d.base = base_in;
                        end
                        if (offset == last_off) begin
                            r_d.state = ST_FULL;
                        end else begin
                            r_d.expect_off = r_q.expect_off + 1'b1;
                        end
                    end else begin
                        r_d.state = ST_IDLE;
                        r_d.err   = 1'b1;
                    end
                end
            end
            ST_FULL: begin
                if (page_ready) begin
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, expect_off: '0, base: '0, bmode: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign page_valid = (r_q.state == ST_FULL);
    assign page_base  = r_q.base;
    assign seq_error  = r_q.err;

    assert_hold_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
        page_valid && !page_ready |=> page_valid && $stable(page_base));

    assert_release_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
        page_valid && page_ready |=> !page_valid);

    assert_error_no_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_error) |-> !page_valid);

    assert_no_store_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        page_valid |-> !store_we);

    assert_start_drops_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> !store_we);

endmodule

// File: tb/test_plb_page_loader.sv
module test_plb_page_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic        bus_we_n = 1'b1;
    logic        bus_ce_n = 1'b1;
    logic [18:0] bus_addr = '0;
    logic        bus_lsb = 1'b0;
    logic [15:0] bus_data = '0;
    logic        byte_mode = 1'b0;
    logic        page_ready = 1'b0;
    logic [6:0]  rd_index = '0;
    logic        page_valid;
    logic [11:0] page_base;
    logic [15:0] rd_data;
    logic        seq_error;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    plb_page_loader i_plb_page_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .bus_we_n   (bus_we_n),
        .bus_ce_n   (bus_ce_n),
        .bus_addr   (bus_addr),
        .bus_lsb    (bus_lsb),
        .bus_data   (bus_data),
        .byte_mode  (byte_mode),
        .page_ready (page_ready),
        .rd_index   (rd_index),
        .page_valid (page_valid),
        .page_base  (page_base),
        .rd_data    (rd_data),
        .seq_error  (seq_error)
    );

    typedef struct packed {
        logic        mode;
        logic        ce_first;
        logic [15:0] seed;
        logic [11:0] base;
    } vec_t;

    localparam int NVEC = 4;
    localparam vec_t VECS [NVEC] = '{
        '{mode: 1'b0, ce_first: 1'b0, seed: 16'h1234, base: 12'h0A5},
        '{mode: 1'b1, ce_first: 1'b0, seed: 16'h00C3, base: 12'hF00},
        '{mode: 1'b0, ce_first: 1'b1, seed: 16'hBEEF, base: 12'h001},
        '{mode: 1'b1, ce_first: 1'b1, seed: 16'h005A, base: 12'h7FF}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] wdat(input logic [15:0] seed, input int i);
        return seed + 16'(i * 16'h0123);
    endfunction

    function automatic logic [7:0] bdat(input logic [15:0] seed, input int j);
        return seed[7:0] ^ 8'(j * 37);
    endfunction

    function automatic logic [15:0] exp_word(input logic mode, input logic [15:0] seed, input int i);
        return mode ? {bdat(seed, 2*i+1), bdat(seed, 2*i)} : wdat(seed, i);
    endfunction

    // one bus cycle; with_start puts cmd_start on the closing cycle
    task automatic bus_write(input logic [18:0] a, input logic l, input logic [15:0] d,
                             input bit ce_first, input bit with_start);
        @(negedge clk);
        bus_addr = a; bus_lsb = l; bus_data = d;
        bus_we_n = 1'b0; bus_ce_n = 1'b0;
        @(negedge clk);
        if (ce_first) bus_ce_n = 1'b1; else bus_we_n = 1'b1;
        cmd_start = with_start;
        @(negedge clk);
        bus_we_n = 1'b1; bus_ce_n = 1'b1; cmd_start = 1'b0;
    endtask

    task automatic pulse_start(input logic mode);
        @(negedge clk);
        cmd_start = 1'b1; byte_mode = mode;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic write_entry(input logic mode, input logic [15:0] seed, input logic [11:0] base,
                               input int k, input bit ce_first);
        if (mode)
            bus_write({base, 7'(k >> 1)}, k[0], {8'(8'hA5 ^ k), bdat(seed, k)}, ce_first, 1'b0);
        else
            bus_write({base, 7'(k)}, 1'b0, wdat(seed, k), ce_first, 1'b0);
    endtask

    task automatic write_run(input logic mode, input logic [15:0] seed, input logic [11:0] base,
                             input int first, input int count, input bit ce_first);
        for (int k = first; k < first + count; k++) write_entry(mode, seed, base, k, ce_first);
    endtask

    task automatic read_word(input int i, output logic [15:0] v);
        rd_index = 7'(i);
        #1;
        v = rd_data;
    endtask

    task automatic accept_page();
        @(negedge clk); page_ready = 1'b1;
        @(negedge clk); page_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] keep;
        repeat (3) @(negedge clk);
        check(page_valid == 1'b0, "R1 valid in reset", page_valid, 0);
        check(seq_error == 1'b0, "R1 error in reset", seq_error, 0);
        rst_n = 1'b1;

        // R1: idle writes after reset
        write_run(1'b0, 16'h7777, 12'h123, 0, 128, 1'b0);
        check(page_valid == 1'b0, "R1 idle writes give no page", page_valid, 0);
        check(seq_error == 1'b0, "R1 idle writes give no error", seq_error, 0);

        // table of full pages: R2 R3 R4 R7
        for (int n = 0; n < NVEC; n++) begin
            int words_bad;
            pulse_start(VECS[n].mode);
            write_run(VECS[n].mode, VECS[n].seed, VECS[n].base, 0,
                      VECS[n].mode ? 256 : 128, VECS[n].ce_first);
            check(page_valid == 1'b1, "R7 page valid after last entry", page_valid, 1);
            check(page_base == VECS[n].base, "R7 page base", page_base, VECS[n].base);
            words_bad = 0;
            for (int i = 0; i < 128; i++) begin
                read_word(i, v);
                if (v != exp_word(VECS[n].mode, VECS[n].seed, i)) begin
                    if (words_bad == 0)
                        check(1'b0, VECS[n].mode ? "R4 byte page word" : "R3 word page word",
                              v, exp_word(VECS[n].mode, VECS[n].seed, i));
                    words_bad++;
                end
            end
            if (words_bad == 0) check(1'b1, "R2 R3 R4 page contents", 0, 0);
            repeat (3) @(negedge clk);
            check(page_valid == 1'b1, "R7 held while not ready", page_valid, 1);
            check(page_base == VECS[n].base, "R7 base held", page_base, VECS[n].base);
            accept_page();
            check(page_valid == 1'b0, "R7 released after ready", page_valid, 0);
        end

        // R5: gap in the sequence
        pulse_start(1'b0);
        write_run(1'b0, 16'h1111, 12'h010, 0, 1, 1'b0);
        write_entry(1'b0, 16'h1111, 12'h010, 2, 1'b0);
        check(seq_error == 1'b1, "R5 skipped offset flags error", seq_error, 1);
        write_run(1'b0, 16'h1111, 12'h010, 1, 127, 1'b0);
        check(page_valid == 1'b0, "R5 no page after error", page_valid, 0);
        check(seq_error == 1'b1, "R5 error stays", seq_error, 1);

        // R9: start clears error; R5: first offset must be zero
        pulse_start(1'b0);
        check(seq_error == 1'b0, "R9 start clears error", seq_error, 0);
        write_entry(1'b0, 16'h2222, 12'h020, 1, 1'b0);
        check(seq_error == 1'b1, "R5 nonzero first offset", seq_error, 1);

        // R6: page change mid-load
        pulse_start(1'b0);
        write_entry(1'b0, 16'h3333, 12'h030, 0, 1'b0);
        write_entry(1'b0, 16'h3333, 12'h031, 1, 1'b0);
        check(seq_error == 1'b1, "R6 base mismatch flags error", seq_error, 1);

        // R9: restart mid-load
        pulse_start(1'b0);
        write_run(1'b0, 16'h4444, 12'h040, 0, 3, 1'b0);
        pulse_start(1'b0);
        write_run(1'b0, 16'h5555, 12'h041, 0, 128, 1'b0);
        check(page_valid == 1'b1, "R9 restart gives page", page_valid, 1);
        check(page_base == 12'h041, "R9 restart base", page_base, 12'h041);
        read_word(2, v);
        check(v == wdat(16'h5555, 2), "R9 restart data", v, wdat(16'h5555, 2));
        accept_page();

        // R9: start on the closing cycle of a write drops that write
        pulse_start(1'b0);
        write_entry(1'b0, 16'h6666, 12'h050, 0, 1'b0);
        bus_write({12'h050, 7'd1}, 1'b0, 16'hDEAD, 1'b0, 1'b1);
        check(seq_error == 1'b0, "R9 coinciding start no error", seq_error, 0);
        write_run(1'b0, 16'h6666, 12'h050, 0, 128, 1'b0);
        check(page_valid == 1'b1, "R9 coinciding write dropped", page_valid, 1);
        read_word(1, v);
        check(v == wdat(16'h6666, 1), "R9 word after coinciding start", v, wdat(16'h6666, 1));

        // R8 R9: writes and start while page waits
        read_word(0, keep);
        bus_write({12'h050, 7'd0}, 1'b0, 16'hCAFE, 1'b0, 1'b1);
        pulse_start(1'b1);
        check(page_valid == 1'b1, "R9 start ignored while valid", page_valid, 1);
        check(page_base == 12'h050, "R8 base unchanged while valid", page_base, 12'h050);
        read_word(0, v);
        check(v == keep, "R8 buffer unchanged while valid", v, keep);
        accept_page();

        // R8: write while idle after handoff
        read_word(5, keep);
        bus_write({12'h050, 7'd5}, 1'b0, 16'hF00D, 1'b0, 1'b0);
        read_word(5, v);
        check(v == keep, "R8 buffer unchanged while idle", v, keep);

        // R4: byte_mode latched at start
        pulse_start(1'b1);
        write_run(1'b1, 16'h0099, 12'h060, 0, 1, 1'b0);
        byte_mode = 1'b0;
        write_run(1'b1, 16'h0099, 12'h060, 1, 255, 1'b0);
        check(page_valid == 1'b1, "R4 mode latched at start", page_valid, 1);
        read_word(127, v);
        check(v == exp_word(1'b1, 16'h0099, 127), "R4 last byte pair", v, exp_word(1'b1, 16'h0099, 127));
        accept_page();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule